// File: doc/BRIEF.md
# Passive FPGA Configuration Loader

This block is the master side of a passive configuration port. Given a start pulse, a byte count and a mode, it resets the target device by pulsing its active-low configuration-request pin. It waits for the device to settle, then pulls bytes from a valid/ready stream and clocks them into the device on a DCLK pin. It supports three data modes: one bit at a time (least significant bit first), a whole byte per clock, and a whole byte followed by three extra clocks. The device status pin is examined before every byte, and an early failure ends the load. After the last byte the block raises DCLK once more, waits, and samples the completion pin.

The pulse length and the two waits are given in microseconds at the start request and converted to system clock cycles using the `CLK_MHZ` parameter. The length of each DCLK phase is given in system clocks. The block reports busy, done and error, and it keeps a count of the bytes it has finished sending. After an abort, that count tells firmware how far the load got.

Top module: `pfcfg_loader`

## Requirements
- R1: After reset, cfg_n_o is 1, dclk_o is 0, s_ready_o, busy_o, done_o and error_o are 0, and sent_count_o is 0.
- R2: An accepted start drives cfg_n_o low for exactly max(low_us_i,2)*CLK_MHZ cycles, starting on the cycle after the start pulse, with dclk_o held low.
- R3: After cfg_n_o returns high, dclk_o stays low for at least max(setup_us_i,1)*CLK_MHZ cycles before its first rise.
- R4: s_ready_o is high only while the block waits for a new byte, bytes remain, and nstatus_i is 1. It is high for one cycle per transfer, and a stalled stream holds the block with dclk_o low.
- R5: In mode 0 (serial), data_o[0] carries the byte least significant bit first, data_o[7:1] is 0, and each byte takes 8 DCLK pulses.
- R6: In mode 1 (parallel), data_o carries the whole byte and each byte takes one DCLK pulse.
- R7: In mode 2 (secure parallel), data_o carries the whole byte, held through four DCLK pulses per byte.
- R8: Each DCLK low phase and high phase lasts max(half_clk_i,1) cycles, and data_o never changes while dclk_o is high.
- R9: If nstatus_i is 0 when a byte is due, the block ends the load on the next edge. It sets error_o, clears busy_o, returns the pins to their idle levels, and keeps sent_count_o at the number of bytes fully clocked.
- R10: After the last byte, dclk_o stays high for max(done_us_i,1)*CLK_MHZ cycles. On the edge that ends this window, conf_done_i is sampled: 1 sets done_o, 0 sets error_o.
- R11: A start with byte_count_i of 0, or with mode 3, sets error_o, clears done_o and sent_count_o, and produces no pin activity and no busy cycle.
- R12: A start pulse while busy_o is 1 has no effect on the load in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request pulse |
| mode_i | input | 2 | 0 serial, 1 parallel, 2 secure parallel, 3 rejected |
| byte_count_i | input | CNT_W | Number of bytes to load |
| low_us_i | input | US_W | Reset pulse length in microseconds |
| setup_us_i | input | US_W | Wait after the pulse in microseconds |
| done_us_i | input | US_W | Wait before sampling completion, in microseconds |
| half_clk_i | input | PH_W | DCLK phase length in system clocks |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Stream byte taken |
| nstatus_i | input | 1 | Device status, 1 means healthy |
| conf_done_i | input | 1 | Device completion flag |
| cfg_n_o | output | 1 | Active-low configuration request pin |
| dclk_o | output | 1 | Configuration clock pin |
| data_o | output | 8 | Configuration data pins |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load succeeded |
| error_o | output | 1 | Last load or request failed |
| sent_count_o | output | CNT_W | Bytes fully clocked in the last load |

## Verification
The bench requests a pulse length below the 2 µs floor. A design that skipped the clamp would release the configuration request early. The serial load feeds bytes with distinct low and high bits, so a design that shifted MSB first, or moved data while DCLK was high, would show wrong pins on some clock. The parallel load stalls the stream every other cycle, which exposes a design that kept ready high or clocked a stale byte. Status is dropped exactly at a byte boundary, which exposes an off-by-one in the sent count. The bench also covers a completion flag held low, a zero phase length, a start while busy, and the two rejected requests. Each of these would show up as a wrong flag, wrong pulse count or stray pin activity.

// File: rtl/pfcfg_pkg.sv
package pfcfg_pkg;

    parameter int US_W   = 12;  // width of microsecond settings
    parameter int PH_W   = 8;   // width of the DCLK phase setting
    parameter int BYTE_W = 8;   // configuration data width
    parameter int PC_W   = 4;   // width of the pulses-per-byte count

    typedef enum logic [1:0] {
        MODE_SERIAL   = 2'd0,
        MODE_PARALLEL = 2'd1,
        MODE_SECURE   = 2'd2,
        MODE_RSVD     = 2'd3
    } ld_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_SETUP,
        ST_CHECK,
        ST_CLKLO,
        ST_CLKHI,
        ST_FINAL
    } ld_state_e;

    typedef struct packed {
        ld_mode_e          mode;
        logic [US_W-1:0]   setup_us;
        logic [US_W-1:0]   done_us;
        logic [PH_W-1:0]   half;
    } ld_cfg_t;

    function automatic logic [US_W-1:0] us_floor(input logic [US_W-1:0] v,
                                                 input logic [US_W-1:0] lo);
        return (v < lo) ? lo : v;
    endfunction

    function automatic logic [PC_W-1:0] pulses_per_byte(input ld_mode_e m);
        case (m)
            MODE_SERIAL: return PC_W'(BYTE_W);
            MODE_SECURE: return PC_W'(4);
            default:     return PC_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/pfcfg_wait_timer.sv
module pfcfg_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pfcfg_byte_shifter.sv
module pfcfg_byte_shifter
    import pfcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              serial_i,
    input  logic [PC_W-1:0]   pulses_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              last_o
);
    logic [BYTE_W-1:0] shreg_q;
    logic [BYTE_W-1:0] data_q;
    logic [PC_W-1:0]   left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            data_q  <= '0;
            left_q  <= '0;
        end else if (load_i) begin
            shreg_q <= byte_i;
            left_q  <= pulses_i - 1'b1;
            data_q  <= serial_i ? BYTE_W'(byte_i[0]) : byte_i;
        end else if (step_i) begin
            left_q <= left_q - 1'b1;
            if (serial_i) begin
                shreg_q <= shreg_q >> 1;
                data_q  <= BYTE_W'(shreg_q[1]);
            end
        end
    end

    assign data_o = data_q;
    assign last_o = (left_q == '0);
endmodule

// File: rtl/pfcfg_loader.sv
module pfcfg_loader
    import pfcfg_pkg::*;
#(
    parameter int CLK_MHZ = 50,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic [CNT_W-1:0]  byte_count_i,
    input  logic [US_W-1:0]   low_us_i,
    input  logic [US_W-1:0]   setup_us_i,
    input  logic [US_W-1:0]   done_us_i,
    input  logic [PH_W-1:0]   half_clk_i,
    input  logic              s_valid_i,
    input  logic [BYTE_W-1:0] s_data_i,
    output logic              s_ready_o,
    input  logic              nstatus_i,
    input  logic              conf_done_i,
    output logic              cfg_n_o,
    output logic              dclk_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o,
    output logic [CNT_W-1:0]  sent_count_o
);
    localparam int MHZ_W = $clog2(CLK_MHZ + 1);
    localparam int TMR_W = US_W + MHZ_W + 1;

    ld_state_e  state_q, state_d;
    ld_cfg_t    cfg_q;
    logic [CNT_W-1:0] total_q, sent_q;
    logic       done_q, error_q;
    logic       tmr_load, tmr_exp;
    logic [TMR_W-1:0] tmr_val, phase_val;
    logic       accept, step, last, more, req_ok;

    assign more      = (sent_q != total_q);
    assign req_ok    = (byte_count_i != '0) && (mode_i != MODE_RSVD);
    assign phase_val = (cfg_q.half == '0) ? '0 : TMR_W'(cfg_q.half) - 1'b1;

    pfcfg_wait_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .load_i(tmr_load),
        .load_val_i(tmr_val), .expired_o(tmr_exp)
    );

    pfcfg_byte_shifter u_shift (
        .clk(clk), .rst(rst), .load_i(accept), .step_i(step),
        .serial_i(cfg_q.mode == MODE_SERIAL),
        .pulses_i(pulses_per_byte(cfg_q.mode)),
        .byte_i(s_data_i), .data_o(data_o), .last_o(last)
    );

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        step     = 1'b0;
        case (state_q)
            ST_IDLE: if (start_i && req_ok) begin
                state_d  = ST_LOW;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(us_floor(low_us_i, US_W'(2)) * CLK_MHZ - 1);
            end
            ST_LOW: if (tmr_exp) begin
                state_d  = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(us_floor(cfg_q.setup_us, US_W'(1)) * CLK_MHZ - 1);
            end
            ST_SETUP: if (tmr_exp) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!more) begin
                    state_d  = ST_FINAL;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(us_floor(cfg_q.done_us, US_W'(1)) * CLK_MHZ - 1);
                end else if (!nstatus_i) begin
                    state_d = ST_IDLE;
                end else if (s_valid_i) begin
                    accept   = 1'b1;
                    state_d  = ST_CLKLO;
                    tmr_load = 1'b1;
                    tmr_val  = phase_val;
                end
            end
            ST_CLKLO: if (tmr_exp) begin
                state_d  = ST_CLKHI;
                tmr_load = 1'b1;
                tmr_val  = phase_val;
            end
            ST_CLKHI: if (tmr_exp) begin
                if (last) begin
                    state_d = ST_CHECK;
                end else begin
                    step     = 1'b1;
                    state_d  = ST_CLKLO;
                    tmr_load = 1'b1;
                    tmr_val  = phase_val;
                end
            end
            ST_FINAL: if (tmr_exp) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            total_q <= '0;
            sent_q  <= '0;
            done_q  <= 1'b0;
            error_q <= 1'b0;
        end else begin
            state_q <= state_d;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    sent_q  <= '0;
                    done_q  <= 1'b0;
                    error_q <= !req_ok;
                    if (req_ok) begin
                        cfg_q   <= '{mode: ld_mode_e'(mode_i), setup_us: setup_us_i,
                                     done_us: done_us_i, half: half_clk_i};
                        total_q <= byte_count_i;
                    end
                end
                ST_CHECK: if (more && !nstatus_i) error_q <= 1'b1;
                ST_CLKHI: if (tmr_exp && last) sent_q <= sent_q + 1'b1;
                ST_FINAL: if (tmr_exp) begin
                    done_q  <= conf_done_i;
                    error_q <= !conf_done_i;
                end
                default: ;
            endcase
        end
    end

    assign s_ready_o    = (state_q == ST_CHECK) && more && nstatus_i;
    assign cfg_n_o      = (state_q != ST_LOW);
    assign dclk_o       = (state_q == ST_CLKHI) || (state_q == ST_FINAL);
    assign busy_o       = (state_q != ST_IDLE);
    assign done_o       = done_q;
    assign error_o      = error_q;
    assign sent_count_o = sent_q;
endmodule

// File: rtl/pfcfg_loader_checker.sv
module pfcfg_loader_checker (
    input logic       clk,
    input logic       rst,
    input logic       s_valid_i,
    input logic       s_ready_o,
    input logic       nstatus_i,
    input logic       cfg_n_o,
    input logic       dclk_o,
    input logic [7:0] data_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       error_o
);
    // R2: configuration request low only inside a load, with DCLK low
    a_r2_low_pulse_quiet: assert property (@(posedge clk) disable iff (rst)
        !cfg_n_o |-> (busy_o && !dclk_o && !s_ready_o));

    // R4: ready only while waiting for a byte with a healthy device
    a_r4_ready_context: assert property (@(posedge clk) disable iff (rst)
        s_ready_o |-> (busy_o && cfg_n_o && !dclk_o && nstatus_i));

    // R4: one cycle of ready per transfer
    a_r4_ready_single: assert property (@(posedge clk) disable iff (rst)
        (s_ready_o && s_valid_i) |=> !s_ready_o);

    // R8: data held while DCLK is high
    a_r8_data_hold: assert property (@(posedge clk) disable iff (rst)
        dclk_o |-> $stable(data_o));

    // R9 and R10: every end of a load reports exactly one outcome
    a_r9_single_outcome: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (done_o != error_o));

    // R11: pins idle whenever no load runs
    a_r11_idle_pins: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (cfg_n_o && !dclk_o && !s_ready_o));
endmodule

bind pfcfg_loader pfcfg_loader_checker u_pfcfg_chk (
    .clk(clk), .rst(rst), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
    .nstatus_i(nstatus_i), .cfg_n_o(cfg_n_o), .dclk_o(dclk_o),
    .data_o(data_o), .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
);

// File: tb/test_pfcfg_loader.sv
module test_pfcfg_loader;
    localparam int CLK_PERIOD = 10;
    localparam int MHZ        = 3;
    localparam int CW         = 16;

    logic clk = 0, rst = 1, start = 0;
    logic [1:0] mode = 0;
    logic [CW-1:0] bcount = 0;
    logic [11:0] low_us = 0, setup_us = 0, done_us = 0;
    logic [7:0] half = 0;
    logic s_valid = 0, s_ready;
    logic [7:0] s_data = 0;
    logic nstatus = 1, conf_done = 0;
    logic cfg_n, dclk, busy, done, error;
    logic [7:0] data;
    logic [CW-1:0] sent;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfcfg_loader #(.CLK_MHZ(MHZ), .CNT_W(CW)) i_pfcfg_loader (
        .clk(clk), .rst(rst), .start_i(start), .mode_i(mode),
        .byte_count_i(bcount), .low_us_i(low_us), .setup_us_i(setup_us),
        .done_us_i(done_us), .half_clk_i(half), .s_valid_i(s_valid),
        .s_data_i(s_data), .s_ready_o(s_ready), .nstatus_i(nstatus),
        .conf_done_i(conf_done), .cfg_n_o(cfg_n), .dclk_o(dclk),
        .data_o(data), .busy_o(busy), .done_o(done), .error_o(error),
        .sent_count_o(sent)
    );

    int checks = 0, fails = 0;
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            if (fails < 30) $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic e_cfg_n = 1, e_dclk = 0, e_busy = 0, e_done = 0, e_err = 0;
    logic [7:0] e_data = 0;
    int e_sent = 0, m_count = 0;
    bit m_wait = 0;

    function automatic int floor_at(input int v, input int lo);
        return (v < lo) ? lo : v;
    endfunction

    task automatic model_load();
        int md, cnt, lowc, setc, donec, h, np;
        logic [7:0] b;
        md = mode; cnt = bcount;
        lowc = floor_at(low_us, 2) * MHZ;
        setc = floor_at(setup_us, 1) * MHZ;
        donec = floor_at(done_us, 1) * MHZ;
        h = floor_at(half, 1);
        np = (md == 0) ? 8 : (md == 2) ? 4 : 1;
        e_busy = 1; e_cfg_n = 0; e_done = 0; e_err = 0; e_sent = 0;
        repeat (lowc) @(posedge clk);
        e_cfg_n = 1;
        repeat (setc) @(posedge clk);
        m_count = cnt; m_wait = 1;
        for (int k = 0; k < cnt; k++) begin
            forever begin
                @(posedge clk);
                if (!nstatus) begin
                    e_err = 1; e_busy = 0; m_wait = 0;
                    return;
                end
                if (s_valid) break;
            end
            b = s_data; m_wait = 0;
            e_data = (md == 0) ? {7'b0, b[0]} : b;
            for (int p = 0; p < np; p++) begin
                repeat (h) @(posedge clk);
                e_dclk = 1;
                repeat (h) @(posedge clk);
                e_dclk = 0;
                if (md == 0 && p < np - 1) e_data = {7'b0, b[p+1]};
            end
            e_sent++; m_wait = 1;
        end
        @(posedge clk);
        m_wait = 0; e_dclk = 1;
        repeat (donec) @(posedge clk);
        e_done = conf_done; e_err = !conf_done;
        e_dclk = 0; e_busy = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (rst) begin
                e_cfg_n = 1; e_dclk = 0; e_busy = 0; e_done = 0; e_err = 0;
                e_data = 0; e_sent = 0; m_wait = 0; m_count = 0;
            end else if (start) begin
                if (bcount == 0 || mode == 2'd3) begin
                    e_err = 1; e_done = 0; e_sent = 0;
                end else begin
                    model_load();
                end
            end
        end
    end

    // per-clock comparison
    bit cmp_en = 0;
    always @(negedge clk) if (cmp_en) begin
        logic e_rdy;
        e_rdy = m_wait && (e_sent < m_count) && nstatus;
        check(cfg_n == e_cfg_n, "R2 cfg_n", cfg_n, e_cfg_n);
        check(dclk == e_dclk, "R8 dclk", dclk, e_dclk);
        check(data == e_data, "R5 data", data, e_data);
        check(s_ready == e_rdy, "R4 ready", s_ready, e_rdy);
        check(busy == e_busy, "R9 busy", busy, e_busy);
        check(done == e_done, "R10 done", done, e_done);
        check(error == e_err, "R9 error", error, e_err);
        check(sent == e_sent, "R9 sent", sent, e_sent);
    end

    // ---------------- stream feeder ----------------
    logic [7:0] q[$];
    bit took = 0, stall = 0, stall_tog = 0;
    always @(posedge clk) took <= s_valid && s_ready;
    always @(negedge clk) begin
        if (took && q.size() > 0) void'(q.pop_front());
        stall_tog = !stall_tog;
        s_valid = (q.size() > 0) && !(stall && stall_tog);
        s_data  = (q.size() > 0) ? q[0] : 8'h00;
    end

    // ---------------- pin monitors ----------------
    int low_cnt = 0, exp_low = 0, gap_cnt = 0, min_gap = 0, rises = 0;
    bit gap_on = 0, prev_cfg = 1, prev_dclk = 0;
    always @(negedge clk) if (cmp_en) begin
        if (!cfg_n) low_cnt++;
        if (cfg_n && !prev_cfg) begin
            check(low_cnt == exp_low, "R2 low width", low_cnt, exp_low);
            low_cnt = 0; gap_on = 1; gap_cnt = 0;
        end
        if (gap_on && dclk) begin
            check(gap_cnt >= min_gap, "R3 setup gap", gap_cnt, min_gap);
            gap_on = 0;
        end else if (gap_on) gap_cnt++;
        if (dclk && !prev_dclk) rises++;
        prev_cfg = cfg_n; prev_dclk = dclk;
    end

    // ---------------- stimulus ----------------
    task automatic kick(input int md, input int cnt, input int lo, input int su,
                        input int du, input int hh);
        @(negedge clk);
        mode = md[1:0]; bcount = cnt[CW-1:0]; low_us = lo[11:0];
        setup_us = su[11:0]; done_us = du[11:0]; half = hh[7:0];
        exp_low = floor_at(lo, 2) * MHZ;
        min_gap = floor_at(su, 1) * MHZ;
        rises = 0;
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        q.delete();
    endtask

    bit wd_hit = 0;
    initial begin
        repeat (150000) @(posedge clk);
        wd_hit = 1;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cmp_en = 1;
        @(negedge clk);
        // R1 reset state
        check(cfg_n == 1 && dclk == 0, "R1 idle pins", {cfg_n, dclk}, 2);
        check(!busy && !done && !error && !s_ready, "R1 flags", {busy, done, error, s_ready}, 0);
        check(sent == 0, "R1 count", sent, 0);

        // serial load, clamped pulse, start while busy (R12)
        q = '{8'hA5, 8'h3C, 8'h81};
        conf_done = 1;
        kick(0, 3, 1, 3, 2, 2);
        repeat (40) @(negedge clk);
        @(negedge clk); mode = 2'd3; bcount = 0; start = 1;
        @(negedge clk); start = 0;
        wait_idle();
        check(done && !error, "R12 busy start ignored", {done, error}, 2);
        check(sent == 3, "R12 count kept", sent, 3);
        check(rises == 3 * 8 + 1, "R5 serial pulses", rises, 25);

        // parallel load with stalls
        q = '{8'h12, 8'hFE, 8'h00, 8'h7B};
        stall = 1;
        kick(1, 4, 2, 1, 1, 1);
        wait_idle();
        stall = 0;
        check(done && !error && sent == 4, "R6 parallel done", sent, 4);
        check(rises == 4 + 1, "R6 parallel pulses", rises, 5);

        // secure parallel, zero phase length
        q = '{8'hC3, 8'h5A, 8'h99};
        kick(2, 3, 3, 2, 1, 0);
        wait_idle();
        check(rises == 3 * 4 + 1, "R7 secure pulses", rises, 13);
        check(done && !error, "R7 secure done", {done, error}, 2);

        // abort on status drop after two bytes
        q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
        kick(1, 5, 2, 1, 1, 2);
        wait (e_sent == 2);
        @(negedge clk); nstatus = 0;
        wait_idle();
        nstatus = 1;
        check(error && !done, "R9 abort flag", {done, error}, 1);
        check(sent == 2, "R9 abort count", sent, 2);
        check(cfg_n && !dclk, "R9 abort pins", {cfg_n, dclk}, 2);

        // completion flag low
        q = '{8'hEE};
        conf_done = 0;
        kick(2, 1, 2, 1, 3, 1);
        wait_idle();
        check(error && !done, "R10 completion low", {done, error}, 1);

        // rejected requests
        conf_done = 1;
        q = '{8'h11};
        kick(1, 1, 2, 1, 1, 1);
        wait_idle();
        check(done && !error, "R10 completion high", {done, error}, 2);
        kick(1, 0, 2, 1, 1, 1);
        check(!busy && error && !done, "R11 zero count", {busy, done, error}, 1);
        repeat (5) @(negedge clk);
        check(rises == 0 && cfg_n, "R11 no pin activity", rises, 0);
        kick(3, 2, 2, 1, 1, 1);
        check(!busy && error && sent == 0, "R11 reserved mode", {busy, error}, 1);
        repeat (5) @(negedge clk);
        check(rises == 0 && cfg_n, "R11 reserved quiet", rises, 0);
        finish_run();
    end

    always @(posedge wd_hit) begin
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask
endmodule